// File: doc/BRIEF.md
# Iterative signed multiply-divide unit with Hi/Lo result pair

This unit gives a RISC core its 32-bit signed multiply and divide. Each operation leaves its result in two dedicated registers, Hi and Lo, rather than in a general register. A one-cycle start pulse supplies an operation select and two operands. The unit then works through one bit per clock and raises busy until the result is committed. The core reads the results back through two always-present read ports, one for Hi and one for Lo, as its move-from-Hi and move-from-Lo operations.

A multiply leaves the 64-bit product split across the pair, with the upper word in Hi. A divide leaves the quotient in Lo and the remainder in Hi. A multiply that targets a general register is built from two operations: the multiply, then a read of Lo. A divisor of zero gives a defined result and a one-cycle flag.

Top module: `mdu_hilo`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears Hi, Lo, busy and the divide-by-zero flag to zero.
- R2: With `op` = 0 (multiply), Hi receives bits 63..32 and Lo receives bits 31..0 of the signed 64-bit product of `opa` and `opb`.
- R3: With `op` = 1 (divide) and a non-zero `opb`, Lo receives the signed quotient of `opa` by `opb`, truncated toward zero. Hi receives the remainder, which carries the sign of `opa`. For -2^31 divided by -1, Lo is 0x80000000 and Hi is 0.
- R4: A start accepted at a clock edge sets busy at that same edge. Busy stays high for exactly 32 cycles. Hi and Lo change only at the edge where busy falls.
- R5: A start pulse that arrives while busy is high is ignored. The running operation keeps its operands and its completion time.
- R6: While busy is high, `hi_out` and `lo_out` keep showing the values from before the operation.
- R7: A divide with `opb` = 0 sets Lo to 0xFFFFFFFF and Hi to `opa`. The flag `div_by_zero` is high for exactly the first cycle in which busy is low again. Every other operation leaves the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 1 | Operation select: 0 multiply, 1 divide |
| opa | input | 32 | First operand (multiplicand or dividend), signed |
| opb | input | 32 | Second operand (multiplier or divisor), signed |
| busy | output | 1 | High while an operation is running |
| hi_out | output | 32 | Move-from-Hi read port |
| lo_out | output | 32 | Move-from-Lo read port |
| div_by_zero | output | 1 | One-cycle flag after a divide by zero completes |

## Verification
A wrong step count shows up at busy. The busy run is 31 or 33 cycles instead of 32, and the error is visible at the edge where the run ends. A corrupted partial product, remainder or sign flag stays hidden during the run, because Hi and Lo are frozen while the unit is busy. It appears only in the first cycle after busy falls, as a wrong Hi or Lo word. The directed tests therefore use operand signs and magnitudes that drive each sign path and carry path, so that every such fault changes a committed word. A start pulse that wrongly takes effect mid-run changes either the run length or the final words.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic {
    MDU_MUL = 1'b0,
    MDU_DIV = 1'b1
  } mdu_op_e;
endpackage

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] fin_hi,
  output logic [W-1:0] fin_lo
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod_q;
  logic [W-1:0]  mcand_q;
  logic          neg_q;
  logic [PW-1:0] prod_nxt;
  logic [PW-1:0] prod_fix;

  function automatic logic [W-1:0] mag(input logic [W-1:0] v);
    return v[W-1] ? (~v + 1'b1) : v;
  endfunction

  // One shift-add round: add the multiplicand to the upper half when the
  // current multiplier bit is set, then shift the whole register right.
  function automatic logic [PW-1:0] mul_step(input logic [PW-1:0] p,
                                             input logic [W-1:0] m);
    logic [W:0] sum;
    sum = {1'b0, p[PW-1:W]} + (p[0] ? {1'b0, m} : '0);
    return {sum, p[W-1:1]};
  endfunction

  assign prod_nxt = mul_step(prod_q, mcand_q);
  assign prod_fix = neg_q ? (~prod_nxt + 1'b1) : prod_nxt;
  assign fin_hi   = prod_fix[PW-1:W];
  assign fin_lo   = prod_fix[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q  <= '0;
      mcand_q <= '0;
      neg_q   <= 1'b0;
    end else if (load) begin
      prod_q  <= {{W{1'b0}}, mag(b)};
      mcand_q <= mag(a);
      neg_q   <= a[W-1] ^ b[W-1];
    end else if (step) begin
      prod_q  <= prod_nxt;
    end
  end
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] fin_hi,
  output logic [W-1:0] fin_lo,
  output logic         zero_div
);
  logic [W-1:0] rem_q, quo_q, dsor_q, dvnd_q;
  logic         negq_q, negr_q, zero_q;
  logic [W-1:0] rem_nxt, quo_nxt;

  function automatic logic [W-1:0] mag(input logic [W-1:0] v);
    return v[W-1] ? (~v + 1'b1) : v;
  endfunction

  // One restoring round: bring in the next dividend bit, subtract the
  // divisor when it fits, record the outcome as a quotient bit.
  function automatic logic [2*W-1:0] div_step(input logic [W-1:0] r,
                                              input logic [W-1:0] q,
                                              input logic [W-1:0] d);
    logic [W:0] sh;
    logic       fits;
    sh   = {r, q[W-1]};
    fits = sh >= {1'b0, d};
    if (fits) sh = sh - {1'b0, d};
    return {sh[W-1:0], q[W-2:0], fits};
  endfunction

  assign {rem_nxt, quo_nxt} = div_step(rem_q, quo_q, dsor_q);
  assign fin_lo   = zero_q ? '1 : (negq_q ? (~quo_nxt + 1'b1) : quo_nxt);
  assign fin_hi   = zero_q ? dvnd_q : (negr_q ? (~rem_nxt + 1'b1) : rem_nxt);
  assign zero_div = zero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsor_q <= '0;
      dvnd_q <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      zero_q <= 1'b0;
    end else if (load) begin
      rem_q  <= '0;
      quo_q  <= mag(a);
      dsor_q <= mag(b);
      dvnd_q <= a;
      negq_q <= a[W-1] ^ b[W-1];
      negr_q <= a[W-1];
      zero_q <= (b == '0);
    end else if (step) begin
      rem_q  <= rem_nxt;
      quo_q  <= quo_nxt;
    end
  end
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out,
  output logic         div_by_zero
);
  localparam int CW = $clog2(W + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  mdu_op_e       op_q;
  logic [W-1:0]  hi_q, lo_q;
  logic          dbz_q;

  // named internal events
  logic          accept;
  logic          last_step;
  logic [W-1:0]  mul_hi, mul_lo, div_hi, div_lo;
  logic          div_zero;

  assign accept    = start && !busy_q;
  assign last_step = busy_q && (cnt_q == CW'(1));

  mdu_mul_core #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .load(accept), .step(busy_q),
    .a(opa), .b(opb), .fin_hi(mul_hi), .fin_lo(mul_lo)
  );

  mdu_div_core #(.W(W)) u_div (
    .clk(clk), .rst(rst), .load(accept), .step(busy_q),
    .a(opa), .b(opb), .fin_hi(div_hi), .fin_lo(div_lo), .zero_div(div_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= MDU_MUL;
      hi_q   <= '0;
      lo_q   <= '0;
      dbz_q  <= 1'b0;
    end else begin
      dbz_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(W);
        op_q   <= mdu_op_e'(op);
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (last_step) begin
          busy_q <= 1'b0;
          if (op_q == MDU_DIV) begin
            hi_q  <= div_hi;
            lo_q  <= div_lo;
            dbz_q <= div_zero;
          end else begin
            hi_q <= mul_hi;
            lo_q <= mul_lo;
          end
        end
      end
    end
  end

  assign busy        = busy_q;
  assign hi_out      = hi_q;
  assign lo_out      = lo_q;
  assign div_by_zero = dbz_q;

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_q);

  // R4
  busy_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && !last_step |=> busy_q && (cnt_q == $past(cnt_q) - 1'b1));

  // R6
  hold_regs_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && !last_step |=> $stable(hi_q) && $stable(lo_q));

  // R5
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    start && busy_q && !last_step |=> $stable(op_q));

  // R7
  dbz_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dbz_q |-> $fell(busy_q) && (op_q == MDU_DIV));
endmodule

// File: tb/mdu_hilo_test.sv
module mdu_hilo_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        op;
  logic [31:0] opa, opb;
  logic        busy;
  logic [31:0] hi_out, lo_out;
  logic        div_by_zero;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  mdu_hilo uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .hi_out(hi_out), .lo_out(lo_out), .div_by_zero(div_by_zero)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  // expected {Hi, Lo}, computed in 64-bit signed arithmetic
  function automatic logic [63:0] model(input bit is_div, input logic [31:0] a,
                                        input logic [31:0] b);
    longint x, y, q, r;
    x = longint'($signed(a));
    y = longint'($signed(b));
    if (!is_div) return 64'(x * y);
    if (b == 32'd0) return {a, 32'hFFFF_FFFF};
    q = x / y;
    r = x % y;
    return {r[31:0], q[31:0]};
  endfunction

  task automatic run_op(input bit is_div, input logic [31:0] a,
                        input logic [31:0] b, input bit inject);
    logic [31:0] prev_hi, prev_lo;
    logic [63:0] exp;
    int  cycles;
    bit  held;
    string req;
    req = is_div ? ((b == 0) ? "R7" : "R3") : "R2";
    exp = model(is_div, a, b);
    prev_hi = hi_out;
    prev_lo = lo_out;
    @(negedge clk);
    start = 1'b1; op = is_div; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0; opa = 32'hDEAD_BEEF; opb = 32'h0000_0005;
    check(busy === 1'b1, "R4", "busy after start", 64'(busy), 64'd1);
    cycles = 0;
    held = 1'b1;
    while (busy === 1'b1 && cycles < 100) begin
      cycles++;
      if (hi_out !== prev_hi || lo_out !== prev_lo) held = 1'b0;
      if (inject && cycles == 5) begin
        start = 1'b1; op = ~is_div; opa = 32'h0000_1234; opb = 32'h0000_0003;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(cycles == 32, inject ? "R5" : "R4", "busy cycles", 64'(cycles), 64'd32);
    check(held, "R6", "hi/lo held while busy", {hi_out, lo_out}, {prev_hi, prev_lo});
    check({hi_out, lo_out} === exp, inject ? "R5" : req, "hi:lo", {hi_out, lo_out}, exp);
    check(div_by_zero === (is_div && b == 0), "R7", "div_by_zero flag",
          64'(div_by_zero), 64'(is_div && b == 0));
    @(negedge clk);
    check(div_by_zero === 1'b0, "R7", "flag one cycle", 64'(div_by_zero), 64'd0);
    check(busy === 1'b0, "R4", "idle after completion", 64'(busy), 64'd0);
  endtask

  task automatic test_reset();
    rst = 1'b1; start = 1'b0; op = 1'b0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0, "R1", "busy at reset", 64'(busy), 64'd0);
    check(hi_out === 32'd0, "R1", "hi at reset", 64'(hi_out), 64'd0);
    check(lo_out === 32'd0, "R1", "lo at reset", 64'(lo_out), 64'd0);
    check(div_by_zero === 1'b0, "R1", "flag at reset", 64'(div_by_zero), 64'd0);
  endtask

  task automatic test_mul();
    run_op(1'b0, 32'd123, 32'd456, 1'b0);                // R2 small positives
    run_op(1'b0, 32'hFFFF_FFF9, 32'd1000, 1'b0);         // R2 negative * positive
    run_op(1'b0, 32'h8000_0001, 32'h8000_0001, 1'b0);    // R2 negative * negative
    run_op(1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0);    // R2 most negative squared
    run_op(1'b0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0);    // R2 -1 * max
    run_op(1'b0, 32'h1234_5678, 32'd0, 1'b0);            // R2 times zero
  endtask

  task automatic test_div();
    run_op(1'b1, 32'd100, 32'd7, 1'b0);                  // R3
    run_op(1'b1, 32'hFFFF_FF9C, 32'd7, 1'b0);            // R3 -100 / 7
    run_op(1'b1, 32'd100, 32'hFFFF_FFF9, 1'b0);          // R3 100 / -7
    run_op(1'b1, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 1'b0);    // R3 -100 / -7
    run_op(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);    // R3 overflow case
    run_op(1'b1, 32'd5, 32'd9, 1'b0);                    // R3 divisor larger
    run_op(1'b1, 32'h7FFF_FFFF, 32'd1, 1'b0);            // R3 divide by one
  endtask

  task automatic test_div_zero();
    run_op(1'b1, 32'hFFFF_FF85, 32'd0, 1'b0);            // R7
    run_op(1'b1, 32'd42, 32'd0, 1'b0);                   // R7
  endtask

  task automatic test_ignore_start();
    run_op(1'b0, 32'd77777, 32'hFFFF_D8F1, 1'b1);        // R5 during multiply
    run_op(1'b1, 32'd999999, 32'd37, 1'b1);              // R5 during divide
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run timed out", 64'd0, 64'd1);
    summary();
  end

  initial begin
    test_reset();
    test_mul();
    test_div();
    test_div_zero();
    test_ignore_start();
    summary();
  end
endmodule